// File: doc/BRIEF.md
# Compare-Output Base Timer

The block is a 16-bit base timer shared by eight compare/capture channels. Each channel holds a compare value. In compare mode a match between the counter and that value toggles the channel's waveform output and raises the channel's request flag. In measure mode, with the channel's function-enable bit set, a rising edge on the channel's capture input copies the counter into the compare register and raises the flag. Switching a channel into measure-and-enable raises its flag on its own a fixed two timer ticks later, and the model keeps that spurious request on purpose.

Software controls the timer through a small write/read register port. One control bit starts the counter; clearing it holds the counter at zero and freezes every waveform output at its current level. A second control bit makes a channel 0 match restart the counter two timer ticks after the match. Channel 0's pin is driven high for those two ticks unless its output-enable bit is off. Request flags are sticky until software writes them to zero. A single summary interrupt pulses when an enabled flag first becomes set.

All timer activity advances on clock edges where `tick` is high, so one timer clock is one such edge.

Top module: `bt_compare_timer`

## Requirements
- R1: After reset the counter reads 0, all pins are low, `irq` is low and every register reads 0.
- R2: While the run bit (control bit 0) is 1, the counter rises by one per tick and wraps from 0xFFFF to 0. While it is 0, the counter is held at 0.
- R3: In compare mode (measure bit 0) a tick with counter equal to the channel's compare value toggles that channel's output level. A pin whose output-enable bit is 0 drives low.
- R4: Clearing the run bit keeps every output level unchanged. After a restart a level changes only at that channel's next match.
- R5: With the restart mode (control bit 1) set, a channel 0 match at count C gives the counter values C, C+1, then 0. Channel 0's pin is high during the C and C+1 periods.
- R6: With channel 0's output-enable bit at 0, its pin stays low during that two-tick window.
- R7: A compare-mode match sets the channel's request flag.
- R8: When a channel's measure and function-enable bits become both 1, its flag sets on the third clock edge after the register write that completes the condition, with ticks on every edge.
- R9: In measure mode with function enable set, a capture input rise seen on a tick loads the current count into the channel's compare register and sets its flag.
- R10: A write to the flag register clears exactly the bits written as 0. A flag set in the same cycle stays set.
- R11: `irq` is high for exactly one clock when a flag whose interrupt-enable bit is 1 goes from 0 to 1. Flags that are already set or not enabled give no pulse.
- R12: Register addresses: 0 control, 1 output enable, 2 measure select, 3 function enable, 4 interrupt enable, 5 flags, 6 counter (read only), 8+j compare of channel j. Channel j uses bit j of each byte register, and reads are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address, for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| cap_in | input | 8 | Per-channel capture inputs |
| pins | output | 8 | Per-channel waveform outputs |
| irq | output | 1 | Summary interrupt pulse |

## Verification
A software write that clears flags can land on the same edge where a channel match sets a flag. The bench times a flag-register write so that its edge is the match edge of a channel being cleared. It expects that flag to survive with a fresh `irq` pulse, while a bit set earlier and written 0 in the same write is cleared. A second overlap is tested in the restart mode: channel 0's own toggle happens inside the forced-high window. The pin is judged over both periods of that window and on the count that follows it.

// File: rtl/bt_pkg.sv
package bt_pkg;
    localparam int NCH = 8;
    localparam int CW  = 16;
    localparam int AW  = 4;
    localparam int SPUR_TICKS = 2;
    localparam int SPW = $clog2(SPUR_TICKS + 1);

    localparam logic [AW-1:0] A_CTRL = 4'd0;
    localparam logic [AW-1:0] A_OE   = 4'd1;
    localparam logic [AW-1:0] A_MEAS = 4'd2;
    localparam logic [AW-1:0] A_FEN  = 4'd3;
    localparam logic [AW-1:0] A_IEN  = 4'd4;
    localparam logic [AW-1:0] A_FLAG = 4'd5;
    localparam logic [AW-1:0] A_CNT  = 4'd6;
    localparam logic [AW-1:0] A_CMP0 = 4'd8;

    typedef struct packed {
        logic rst0;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/bt_counter.sv
module bt_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          rst_mode,
    input  logic          hit0,
    output logic [CW-1:0] count,
    output logic          gap
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count <= '0;
            gap   <= 1'b0;
        end else if (tick) begin
            if (gap) begin
                count <= '0;
                gap   <= 1'b0;
            end else begin
                count <= count + 1'b1;
                gap   <= rst_mode && hit0;
            end
        end
    end
endmodule

// File: rtl/bt_channel.sv
module bt_channel #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic [CW-1:0] count,
    input  logic          meas,
    input  logic          fen,
    input  logic          cap_in,
    input  logic          wr_cmp,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cmp,
    output logic          out_lvl,
    output logic          req
);
    import bt_pkg::*;

    logic           mf, mf_q, cap_q, hit, tog, cap_edge, spur;
    logic [SPW-1:0] cd;

    assign mf       = meas & fen;
    assign hit      = run && (count == cmp);
    assign tog      = tick && hit && !meas;
    assign cap_edge = tick && mf && cap_in && !cap_q;
    assign spur     = tick && (cd == SPW'(1));
    assign req      = tog | spur | cap_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp     <= '0;
            out_lvl <= 1'b0;
            mf_q    <= 1'b0;
            cap_q   <= 1'b0;
            cd      <= '0;
        end else begin
            mf_q <= mf;
            if (tick) cap_q <= cap_in;
            if (wr_cmp)        cmp <= wdata;
            else if (cap_edge) cmp <= count;
            if (tog) out_lvl <= ~out_lvl;
            if (!mf)                 cd <= '0;
            else if (!mf_q)          cd <= SPW'(SPUR_TICKS);
            else if (tick && cd != 0) cd <= cd - 1'b1;
        end
    end
endmodule

// File: rtl/bt_flags.sv
module bt_flags #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set,
    input  logic           clr_wr,
    input  logic [NCH-1:0] wdata,
    input  logic [NCH-1:0] ien,
    output logic [NCH-1:0] flags,
    output logic           irq
);
    logic [NCH-1:0] keep;
    assign keep = clr_wr ? wdata : '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
            irq   <= 1'b0;
        end else begin
            flags <= (flags & keep) | set;
            irq   <= |(set & ~flags & ien);
        end
    end
endmodule

// File: rtl/bt_compare_timer.sv
module bt_compare_timer #(
    parameter int NCH = bt_pkg::NCH,
    parameter int CW  = bt_pkg::CW,
    parameter int AW  = bt_pkg::AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [CW-1:0]  reg_wdata,
    output logic [CW-1:0]  reg_rdata,
    input  logic [NCH-1:0] cap_in,
    output logic [NCH-1:0] pins,
    output logic           irq
);
    import bt_pkg::*;

    ctrl_t          ctrl_q;
    logic           run_q, rst0_q, gap, hit0, force0, flag_wr;
    logic [NCH-1:0] oe_q, meas_q, fen_q, ien_q, flags, out_lvl, req, wr_cmp;
    logic [CW-1:0]  count;
    logic [CW-1:0]  cmp_arr [NCH];

    assign run_q   = ctrl_q.run;
    assign rst0_q  = ctrl_q.rst0;
    assign flag_wr = reg_wr && (reg_addr == A_FLAG);
    assign hit0    = run_q && (count == cmp_arr[0]);
    assign force0  = rst0_q && (hit0 || gap);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            oe_q   <= '0;
            meas_q <= '0;
            fen_q  <= '0;
            ien_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    ctrl_q.run  <= reg_wdata[0];
                    ctrl_q.rst0 <= reg_wdata[1];
                end
                A_OE:   oe_q   <= reg_wdata[NCH-1:0];
                A_MEAS: meas_q <= reg_wdata[NCH-1:0];
                A_FEN:  fen_q  <= reg_wdata[NCH-1:0];
                A_IEN:  ien_q  <= reg_wdata[NCH-1:0];
                default: ;
            endcase
        end
    end

    bt_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .run(run_q),
        .rst_mode(rst0_q), .hit0(hit0), .count(count), .gap(gap)
    );

    for (genvar j = 0; j < NCH; j++) begin : g_ch
        assign wr_cmp[j] = reg_wr && (reg_addr == A_CMP0 + AW'(j));
        bt_channel #(.CW(CW)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .run(run_q), .count(count),
            .meas(meas_q[j]), .fen(fen_q[j]), .cap_in(cap_in[j]),
            .wr_cmp(wr_cmp[j]), .wdata(reg_wdata), .cmp(cmp_arr[j]),
            .out_lvl(out_lvl[j]), .req(req[j])
        );
        if (j == 0) begin : g_pin0
            assign pins[j] = oe_q[j] & (out_lvl[j] | force0);
        end else begin : g_pinn
            assign pins[j] = oe_q[j] & out_lvl[j];
        end
    end

    bt_flags #(.NCH(NCH)) u_flg (
        .clk(clk), .rst(rst), .set(req), .clr_wr(flag_wr),
        .wdata(reg_wdata[NCH-1:0]), .ien(ien_q), .flags(flags), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata = CW'({rst0_q, run_q});
            A_OE:   reg_rdata = CW'(oe_q);
            A_MEAS: reg_rdata = CW'(meas_q);
            A_FEN:  reg_rdata = CW'(fen_q);
            A_IEN:  reg_rdata = CW'(ien_q);
            A_FLAG: reg_rdata = CW'(flags);
            A_CNT:  reg_rdata = count;
            default: ;
        endcase
        for (int j = 0; j < NCH; j++) begin
            if (reg_addr == A_CMP0 + AW'(j)) reg_rdata = cmp_arr[j];
        end
    end
endmodule

// File: rtl/bt_checker.sv
module bt_checker #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic           tick,
    input logic           run_q,
    input logic           gap,
    input logic [CW-1:0]  count,
    input logic [NCH-1:0] flags,
    input logic           flag_wr,
    input logic [NCH-1:0] ien_q,
    input logic           irq,
    input logic [NCH-1:0] out_lvl
);
    assert_stop_clears_R2: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> count == '0);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && !gap) |=> count == $past(count) + 1'b1);

    assert_gap_restart_R5: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && gap) |=> count == '0);

    assert_levels_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> out_lvl == $past(out_lvl));

    assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> (flags & $past(flags)) == $past(flags));

    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags & ~$past(flags) & $past(ien_q)) != '0);
endmodule

bind bt_compare_timer bt_checker #(.NCH(NCH), .CW(CW)) chk_i (
    .clk(clk), .rst(rst), .tick(tick), .run_q(run_q), .gap(gap),
    .count(count), .flags(flags), .flag_wr(flag_wr), .ien_q(ien_q),
    .irq(irq), .out_lvl(out_lvl)
);

// File: tb/bt_compare_timer_tb_top.sv
`timescale 1ns/1ps
module bt_compare_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  cap_in = '0;
    logic [7:0]  pins;
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bt_compare_timer dut_i (
        .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in),
        .pins(pins), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // called at a negedge; the write edge is the next posedge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        rd(4'd6, v); chk("R1 count", v, 0);
        rd(4'd5, v); chk("R1 flags", v, 0);
        rd(4'd0, v); chk("R1 ctrl", v, 0);
        chk("R1 pins", pins, 0);
        chk("R1 irq", irq, 0);
    endtask

    task automatic t_map;
        logic [15:0] v;
        for (int j = 0; j < 8; j++) wr(4'(8 + j), 16'h8000 + 16'(j));
        rd(4'd11, v); chk("R12 cmp3 readback", v, 16'h8003);
        wr(4'd3, 16'h0005);
        rd(4'd3, v); chk("R12 fen readback", v, 16'h0005);
        wr(4'd3, 16'h0000);
    endtask

    task automatic t_toggle_hold;
        logic [15:0] v;
        wr(4'd10, 16'd10); wr(4'd11, 16'd5);
        wr(4'd1, 16'h04);  wr(4'd4, 16'h04);
        wr(4'd0, 16'h01);
        for (int k = 1; k <= 12; k++) begin
            step(1);
            if (k == 6) begin
                rd(4'd5, v); chk("R7 flag3 at match", v[3], 1);
                chk("R3 pin3 disabled low", pins[3], 0);
                chk("R11 no irq for disabled ch3", irq, 0);
            end
            if (k == 10) chk("R3 pin2 before match", pins[2], 0);
            if (k == 11) begin
                chk("R3 pin2 toggled", pins[2], 1);
                rd(4'd5, v); chk("R7 flag2 at match", v[2], 1);
                chk("R11 irq pulse", irq, 1);
            end
            if (k == 12) begin
                chk("R11 irq one clock", irq, 0);
                rd(4'd6, v); chk("R2 count steps", v, 12);
            end
        end
        wr(4'd0, 16'h00);
        step(1);
        rd(4'd6, v); chk("R2 stopped count zero", v, 0);
        step(3);
        chk("R4 pin2 held while stopped", pins[2], 1);
        wr(4'd0, 16'h01);
        step(10); chk("R4 pin2 held until match", pins[2], 1);
        step(1);  chk("R4 pin2 toggles at match", pins[2], 0);
        wr(4'd0, 16'h00); step(1);
    endtask

    task automatic t_ch0;
        logic [15:0] v;
        wr(4'd8, 16'd6); wr(4'd1, 16'h01); wr(4'd0, 16'h03);
        for (int k = 1; k <= 16; k++) begin
            step(1);
            if (k == 5) chk("R5 pin0 low before match", pins[0], 0);
            if (k == 6) chk("R5 pin0 forced at match", pins[0], 1);
            if (k == 7) begin
                chk("R5 pin0 forced second tick", pins[0], 1);
                rd(4'd6, v); chk("R5 count C+1", v, 7);
            end
            if (k == 8) begin rd(4'd6, v); chk("R5 count restarted", v, 0); end
            if (k == 15) chk("R5 pin0 forced in gap", pins[0], 1);
            if (k == 16) chk("R5 pin0 released after gap", pins[0], 0);
        end
        wr(4'd0, 16'h00); step(1);
        wr(4'd1, 16'h00); wr(4'd0, 16'h03);
        step(6); chk("R6 pin0 low with oe off", pins[0], 0);
        step(1); chk("R6 pin0 low second tick", pins[0], 0);
        wr(4'd0, 16'h00); step(1);
    endtask

    task automatic t_clear;
        logic [15:0] v;
        wr(4'd5, 16'h00);
        wr(4'd9, 16'd3); wr(4'd12, 16'd5); wr(4'd4, 16'h12);
        wr(4'd0, 16'h01);
        step(4);
        rd(4'd5, v); chk("R7 flag1 set", v[1], 1);
        step(1);
        wr(4'd5, 16'h00ED);
        rd(4'd5, v); chk("R10 set beats clear", v, 16'h18);
        chk("R11 irq on set during clear", irq, 1);
        wr(4'd5, 16'h00F7);
        rd(4'd5, v); chk("R10 only zero bits cleared", v, 16'h11);
        chk("R11 no irq for bit0 not enabled", irq, 0);
        wr(4'd0, 16'h00); step(1);
    endtask

    task automatic t_spur_cap;
        logic [15:0] v;
        wr(4'd5, 16'h00);
        wr(4'd3, 16'h40);
        wr(4'd2, 16'h40);
        step(2); rd(4'd5, v); chk("R8 no flag yet", v[6], 0);
        step(1); rd(4'd5, v); chk("R8 spurious flag", v[6], 1);
        wr(4'd5, 16'h00);
        wr(4'd0, 16'h01);
        step(4);
        cap_in[6] = 1'b1;
        step(1);
        rd(4'd5, v);  chk("R9 capture flag", v[6], 1);
        rd(4'd14, v); chk("R9 captured count", v, 4);
        cap_in[6] = 1'b0;
        wr(4'd0, 16'h00); step(1);
    endtask

    task automatic t_wrap;
        logic [15:0] v;
        wr(4'd2, 16'h00); wr(4'd3, 16'h00);
        wr(4'd0, 16'h01);
        step(65535);
        rd(4'd6, v); chk("R2 count max", v, 16'hFFFF);
        step(1);
        rd(4'd6, v); chk("R2 wrap to zero", v, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_toggle_hold();
        t_ch0();
        t_clear();
        t_spur_cap();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule